// File: doc/BRIEF.md
# Multi-Channel TDD Timing Generator

A frame-based sequencer that drives a bank of control lines, for example the transmit/receive switching of a time-division-duplex radio front end, or any other task that needs several signals asserted at fixed points inside a repeating period. An internal reference counter steps through a programmable frame. Every channel owns a start count and a stop count in that frame, plus an enable bit and a polarity bit. The channel line is driven active while the counter lies inside its window.

Software loads the configuration through a small word-addressed register port and enables the block. The block then waits for a sync event from the selected source, which is an external pin, an internal periodic pulse or a software trigger bit. After the sync it waits the programmed startup delay and then plays a burst with a programmed number of frames. It then re-arms for the next sync. A burst length of zero runs without end. Clearing the enable returns the block to idle at once.

Register map (word addresses): 0x00 version (read-only), 0x01 control, 0x02 startup delay, 0x03 frame length, 0x04 frames per burst, 0x05 internal sync period, 0x06 channel enable mask (bit i = channel i), 0x07 channel polarity mask (bit i = channel i). Channel i uses 0x10+2i for its start count and 0x11+2i for its stop count. Control bits: bit 0 global enable, bits 2:1 sync source (0 external, 1 internal, 2 software, 3 none), bit 3 software trigger.

Top module: `tdd_seq_top`

## Requirements
- R1: Address 0x00 always reads 0x00020100, and writes to it have no effect.
- R2: Every configuration register reads back the value last written. Control bit 3 is a write-only trigger and always reads 0.
- R3: With the reference count c and a channel's start s and stop e: for s<e the window holds s<=c<e, for s>e it wraps and holds c>=s or c<e, and for s==e it is never active.
- R4: A channel output equals its polarity bit XOR (burst running AND channel enabled AND in window). So a disabled channel, and every channel outside a running frame, sits at its polarity level.
- R5: In a frame of length L (L>=1) the reference count runs 0,1,..,L-1 and restarts at 0.
- R6: After an accepted sync the block spends exactly D clock cycles in its startup delay (outputs inactive, burst_active high) before count 0 is played.
- R7: With B frames per burst (B>=1), generation stops after B*L counted cycles. burst_active falls, the outputs go inactive, and the block re-arms for the next sync.
- R8: A frames-per-burst value of 0 repeats frames without end.
- R9: The external sync pin passes through two synchronizing flops and is rising-edge detected. A rise driven before clock edge E0 starts the burst at edge E2, and a level held high does not start another burst.
- R10: With the internal source and period P, sync pulses come every P cycles while enabled, so consecutive bursts shorter than P start exactly P cycles apart.
- R11: Writing control with bit 3 set while software sync is selected and the block is waiting starts a burst. The burst reaches its first state one edge after the write edge.
- R12: Sync events that arrive during a burst are ignored, and the frame count carries on undisturbed.
- R13: Clearing the global enable moves the block to idle on the next edge and drives every output to its polarity level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Word address for read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| ext_sync | input | 1 | Asynchronous external sync pin |
| ch_out | output | NUM_CH | Channel control lines |
| burst_active | output | 1 | High during startup delay and frame playback |

## Verification
The assertions assume that software does not rewrite the frame length while a burst plays, and that the frame length is nonzero whenever the engine runs. The counter bound and the rule that a mid-burst sync is ignored both depend on that. The bench reprograms frame, burst, delay and channel windows only after clearing the enable. It draws frame lengths from 3 upward, and its only mid-burst traffic is a software trigger write. The external pin changes only at falling clock edges and is held for several cycles, so the synchronizer never sees a pulse narrower than a clock.

// File: rtl/tdd_pkg.sv
package tdd_pkg;
    localparam int unsigned MAXW = 32;
    localparam logic [31:0] VERSION_WORD = 32'h0002_0100;

    localparam int unsigned A_VERSION = 0;
    localparam int unsigned A_CTRL    = 1;
    localparam int unsigned A_DELAY   = 2;
    localparam int unsigned A_FRAME   = 3;
    localparam int unsigned A_BURST   = 4;
    localparam int unsigned A_PERIOD  = 5;
    localparam int unsigned A_CHEN    = 6;
    localparam int unsigned A_CHPOL   = 7;
    localparam int unsigned A_CHBASE  = 16;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_INT  = 2'd1,
        SRC_SW   = 2'd2,
        SRC_NONE = 2'd3
    } sync_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_RUN   = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic      enable;
        sync_src_e src;
    } ctrl_t;

    // Window membership, wrapping when start lies beyond stop.
    function automatic logic in_window(input logic [MAXW-1:0] cnt,
                                       input logic [MAXW-1:0] start,
                                       input logic [MAXW-1:0] stop);
        if (start < stop)      return (cnt >= start) && (cnt < stop);
        else if (start > stop) return (cnt >= start) || (cnt < stop);
        else                   return 1'b0;
    endfunction
endpackage

// File: rtl/tdd_regs.sv
module tdd_regs
    import tdd_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [31:0]                      wdata,
    output logic [31:0]                      rdata,
    output ctrl_t                            ctrl,
    output logic                             sw_req,
    output logic [CNT_W-1:0]                 delay,
    output logic [CNT_W-1:0]                 frame_len,
    output logic [CNT_W-1:0]                 burst_len,
    output logic [CNT_W-1:0]                 period,
    output logic [NUM_CH-1:0]                ch_en,
    output logic [NUM_CH-1:0]                ch_pol,
    output logic [NUM_CH-1:0][CNT_W-1:0]     ch_start,
    output logic [NUM_CH-1:0][CNT_W-1:0]     ch_stop
);
    localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_DELAY  = ADDR_W'(A_DELAY);
    localparam logic [ADDR_W-1:0] AD_FRAME  = ADDR_W'(A_FRAME);
    localparam logic [ADDR_W-1:0] AD_BURST  = ADDR_W'(A_BURST);
    localparam logic [ADDR_W-1:0] AD_PERIOD = ADDR_W'(A_PERIOD);
    localparam logic [ADDR_W-1:0] AD_CHEN   = ADDR_W'(A_CHEN);
    localparam logic [ADDR_W-1:0] AD_CHPOL  = ADDR_W'(A_CHPOL);
    localparam logic [ADDR_W-1:0] AD_VER    = ADDR_W'(A_VERSION);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '{enable: 1'b0, src: SRC_SW};
            sw_req    <= 1'b0;
            delay     <= '0;
            frame_len <= '0;
            burst_len <= '0;
            period    <= '0;
            ch_en     <= '0;
            ch_pol    <= '0;
        end else begin
            sw_req <= we && (addr == AD_CTRL) && wdata[3];
            if (we) begin
                case (addr)
                    AD_CTRL: begin
                        ctrl.enable <= wdata[0];
                        ctrl.src    <= sync_src_e'(wdata[2:1]);
                    end
                    AD_DELAY:  delay     <= wdata[CNT_W-1:0];
                    AD_FRAME:  frame_len <= wdata[CNT_W-1:0];
                    AD_BURST:  burst_len <= wdata[CNT_W-1:0];
                    AD_PERIOD: period    <= wdata[CNT_W-1:0];
                    AD_CHEN:   ch_en     <= wdata[NUM_CH-1:0];
                    AD_CHPOL:  ch_pol    <= wdata[NUM_CH-1:0];
                    default: ;
                endcase
            end
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chreg
        localparam logic [ADDR_W-1:0] AD_START = ADDR_W'(A_CHBASE + 2 * i);
        localparam logic [ADDR_W-1:0] AD_STOP  = ADDR_W'(A_CHBASE + 2 * i + 1);
        always_ff @(posedge clk) begin
            if (rst) begin
                ch_start[i] <= '0;
                ch_stop[i]  <= '0;
            end else if (we) begin
                if (addr == AD_START) ch_start[i] <= wdata[CNT_W-1:0];
                if (addr == AD_STOP)  ch_stop[i]  <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AD_VER:    rdata = VERSION_WORD;
            AD_CTRL:   rdata = {29'd0, ctrl.src, ctrl.enable};
            AD_DELAY:  rdata = 32'(delay);
            AD_FRAME:  rdata = 32'(frame_len);
            AD_BURST:  rdata = 32'(burst_len);
            AD_PERIOD: rdata = 32'(period);
            AD_CHEN:   rdata = 32'(ch_en);
            AD_CHPOL:  rdata = 32'(ch_pol);
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(A_CHBASE + 2 * i))     rdata = 32'(ch_start[i]);
            if (addr == ADDR_W'(A_CHBASE + 2 * i + 1)) rdata = 32'(ch_stop[i]);
        end
    end
endmodule

// File: rtl/tdd_sync.sv
module tdd_sync
    import tdd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  sync_src_e        src,
    input  logic             ext_pin,
    input  logic             sw_req,
    input  logic [CNT_W-1:0] period,
    output logic             sync_evt
);
    logic             s1, s2, s3;
    logic             ext_rise;
    logic             int_hit;
    logic [CNT_W-1:0] int_cnt;

    assign ext_rise = s2 & ~s3;
    assign int_hit  = (period != '0) && (int_cnt >= period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= 1'b0;
            s2      <= 1'b0;
            s3      <= 1'b0;
            int_cnt <= '0;
        end else begin
            s1 <= ext_pin;
            s2 <= s1;
            s3 <= s2;
            if (!enable || int_hit) int_cnt <= '0;
            else                    int_cnt <= int_cnt + 1'b1;
        end
    end

    always_comb begin
        case (src)
            SRC_EXT: sync_evt = ext_rise;
            SRC_INT: sync_evt = enable && int_hit;
            SRC_SW:  sync_evt = sw_req;
            default: sync_evt = 1'b0;
        endcase
    end

    // R9: the edge detector yields single-cycle events
    assert_ext_edge_single_R9: assert property (@(posedge clk) disable iff (rst)
        ext_rise |=> !ext_rise);
endmodule

// File: rtl/tdd_engine.sv
module tdd_engine
    import tdd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             sync_evt,
    input  logic [CNT_W-1:0] delay,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] burst_len,
    output eng_state_e       state,
    output logic [CNT_W-1:0] ref_cnt
);
    logic [CNT_W-1:0] dly_cnt;
    logic [CNT_W-1:0] frm_cnt;
    logic             frame_end;

    assign frame_end = ref_cnt >= frame_len - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state   <= ST_IDLE;
            ref_cnt <= '0;
            dly_cnt <= '0;
            frm_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (sync_evt) begin
                        ref_cnt <= '0;
                        dly_cnt <= '0;
                        frm_cnt <= '0;
                        state   <= (delay == '0) ? ST_RUN : ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (dly_cnt + 1'b1 >= delay) begin
                        state   <= ST_RUN;
                        ref_cnt <= '0;
                    end else begin
                        dly_cnt <= dly_cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (frame_end) begin
                        ref_cnt <= '0;
                        if (burst_len != '0 && frm_cnt >= burst_len - 1'b1) state <= ST_WAIT;
                        else frm_cnt <= frm_cnt + 1'b1;
                    end else begin
                        ref_cnt <= ref_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: the count stays inside the frame while playing
    assert_cnt_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && frame_len != '0) |-> ref_cnt < frame_len);

    // R12: a sync during playback does not restart the count
    assert_sync_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && enable && sync_evt && !frame_end) |=> ref_cnt == $past(ref_cnt) + 1'b1);

    // R13: clearing the enable reaches idle on the next edge
    assert_disable_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !enable |=> state == ST_IDLE);
endmodule

// File: rtl/tdd_chan.sv
module tdd_chan
    import tdd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] stop,
    input  logic             en,
    input  logic             pol,
    output logic             line
);
    logic active;
    assign active = run && en && in_window(MAXW'(cnt), MAXW'(start), MAXW'(stop));
    assign line   = pol ^ active;
endmodule

// File: rtl/tdd_seq_top.sv
module tdd_seq_top
    import tdd_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              ext_sync,
    output logic [NUM_CH-1:0] ch_out,
    output logic              burst_active
);
    ctrl_t                         ctrl;
    logic                          sw_req;
    logic [CNT_W-1:0]              delay, frame_len, burst_len, period;
    logic [NUM_CH-1:0]             ch_en, ch_pol;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_start, ch_stop;
    logic                          sync_evt;
    eng_state_e                    state;
    logic [CNT_W-1:0]              ref_cnt;
    logic                          run;

    tdd_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .ctrl(ctrl), .sw_req(sw_req), .delay(delay),
        .frame_len(frame_len), .burst_len(burst_len), .period(period),
        .ch_en(ch_en), .ch_pol(ch_pol), .ch_start(ch_start), .ch_stop(ch_stop)
    );

    tdd_sync #(.CNT_W(CNT_W)) u_sync (
        .clk(clk), .rst(rst), .enable(ctrl.enable), .src(ctrl.src),
        .ext_pin(ext_sync), .sw_req(sw_req), .period(period), .sync_evt(sync_evt)
    );

    tdd_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst(rst), .enable(ctrl.enable), .sync_evt(sync_evt),
        .delay(delay), .frame_len(frame_len), .burst_len(burst_len),
        .state(state), .ref_cnt(ref_cnt)
    );

    assign run          = (state == ST_RUN);
    assign burst_active = (state == ST_RUN) || (state == ST_DELAY);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tdd_chan #(.CNT_W(CNT_W)) u_chan (
            .run(run), .cnt(ref_cnt), .start(ch_start[i]), .stop(ch_stop[i]),
            .en(ch_en[i]), .pol(ch_pol[i]), .line(ch_out[i])
        );

        // R3: an empty window never drives the line active
        assert_empty_window_R3: assert property (@(posedge clk) disable iff (rst)
            (ch_start[i] == ch_stop[i]) |-> ch_out[i] == ch_pol[i]);
    end

    // R4: outside playback every line rests at its polarity level
    assert_rest_level_R4: assert property (@(posedge clk) disable iff (rst)
        !burst_active |-> ch_out == ch_pol);
endmodule

// File: tb/tdd_seq_top_test.sv
module tdd_seq_top_test;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ext_sync = 1'b0;
    logic [NCH-1:0] ch_out;
    logic        burst_active;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int b_start[NCH], b_stop[NCH];
    logic [NCH-1:0] b_en, b_pol;
    int L, B, D;
    logic [31:0] ctrl_val;

    tdd_seq_top uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_sync(ext_sync),
        .ch_out(ch_out), .burst_active(burst_active)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] model(input int k);
        logic [NCH-1:0] v;
        int c;
        c = k % L;
        for (int i = 0; i < NCH; i++) begin
            logic act;
            if (b_start[i] < b_stop[i])      act = (c >= b_start[i]) && (c < b_stop[i]);
            else if (b_start[i] > b_stop[i]) act = (c >= b_start[i]) || (c < b_stop[i]);
            else                             act = 1'b0;
            v[i] = b_pol[i] ^ (b_en[i] & act);
        end
        return v;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        cfg_addr = 8'(a);
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic load_cfg(input int src, input int per);
        wr(1, 32'd0);
        wr(3, 32'(L)); wr(4, 32'(B)); wr(2, 32'(D)); wr(5, 32'(per));
        for (int i = 0; i < NCH; i++) begin
            wr(16 + 2 * i, 32'(b_start[i]));
            wr(17 + 2 * i, 32'(b_stop[i]));
        end
        wr(6, 32'(b_en)); wr(7, 32'(b_pol));
        ctrl_val = 32'(1 | (src << 1));
        wr(1, ctrl_val);
        @(negedge clk);
    endtask

    // Entered at the negedge before the edge that accepts the sync.
    task automatic run_burst(input int poke);
        chk("R11 waiting before sync", 32'(burst_active), 32'd0);
        for (int d = 0; d < D; d++) begin
            @(negedge clk);
            chk("R6 delay active", 32'(burst_active), 32'd1);
            chk("R6 delay lines inactive", 32'(ch_out), 32'(b_pol));
        end
        for (int k = 0; k < L * B; k++) begin
            @(negedge clk);
            if (k == poke + 1) cfg_we = 1'b0;
            if (poke >= 0 && k > poke) chk("R12 sync ignored", 32'(ch_out), 32'(model(k)));
            else chk("R3 R4 R5 window", 32'(ch_out), 32'(model(k)));
            chk("R5 burst_active in frame", 32'(burst_active), 32'd1);
            if (k == poke) begin
                cfg_we = 1'b1; cfg_addr = 8'd1; cfg_wdata = ctrl_val | 32'd8;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R7 burst stopped", 32'(burst_active), 32'd0);
        chk("R7 lines inactive after burst", 32'(ch_out), 32'(b_pol));
    endtask

    task automatic sw_trig();
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'd1; cfg_wdata = ctrl_val | 32'd8;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int t1, t2;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 reset lines", 32'(ch_out), 32'd0);
        chk("R13 reset idle", 32'(burst_active), 32'd0);
        rd_chk("R1 version", 0, 32'h0002_0100);
        wr(0, 32'hFFFF_FFFF);
        rd_chk("R1 version after write", 0, 32'h0002_0100);

        wr(3, 32'd1234); wr(17, 32'd77); wr(7, 32'h5A);
        rd_chk("R2 frame readback", 3, 32'd1234);
        rd_chk("R2 stop readback", 17, 32'd77);
        rd_chk("R2 polarity readback", 7, 32'h5A);
        wr(1, 32'h0000_000C);
        rd_chk("R2 trigger bit reads zero", 1, 32'h0000_0004);
        wr(1, 32'd0);

        // Directed windows: normal, wrap, empty, disabled, inverted, full, wrap-one
        L = 8; B = 2; D = 3;
        b_start = '{2, 6, 3, 1, 0, 0, 7, 1};
        b_stop  = '{5, 2, 3, 4, 4, 8, 0, 2};
        b_en  = 8'b0111_0111;
        b_pol = 8'b0001_1000;
        load_cfg(2, 0);
        sw_trig();
        run_burst(-1);
        sw_trig();           // R7 re-arm without re-enable
        run_burst(-1);

        // R12: trigger during playback
        L = 10; B = 1; D = 0;
        load_cfg(2, 0);
        sw_trig();
        run_burst(3);

        // Random configurations
        for (int it = 0; it < 8; it++) begin
            L = 3 + int'($urandom_range(0, 17));
            B = 1 + int'($urandom_range(0, 2));
            D = int'($urandom_range(0, 5));
            for (int i = 0; i < NCH; i++) begin
                b_start[i] = int'($urandom_range(0, L));
                b_stop[i]  = int'($urandom_range(0, L));
            end
            b_en  = NCH'($urandom);
            b_pol = NCH'($urandom);
            load_cfg(2, 0);
            sw_trig();
            run_burst(-1);
        end

        // R8 continuous, then R13 disable mid-frame
        L = 5; B = 0; D = 1;
        load_cfg(2, 0);
        sw_trig();
        @(negedge clk);
        chk("R6 delay active", 32'(burst_active), 32'd1);
        for (int k = 0; k < 3 * L; k++) begin
            @(negedge clk);
            chk("R8 continuous frames", 32'(ch_out), 32'(model(k)));
            chk("R8 still active", 32'(burst_active), 32'd1);
        end
        cfg_we = 1'b1; cfg_addr = 8'd1; cfg_wdata = 32'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        chk("R13 idle after disable", 32'(burst_active), 32'd0);
        chk("R13 lines inactive after disable", 32'(ch_out), 32'(b_pol));

        // R9 external sync timing and level hold
        L = 4; B = 1; D = 0;
        load_cfg(0, 0);
        ext_sync = 1'b1;
        @(negedge clk);
        chk("R9 not yet after one edge", 32'(burst_active), 32'd0);
        @(negedge clk);
        run_burst(-1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 held level no retrigger", 32'(burst_active), 32'd0);
        end
        ext_sync = 1'b0;

        // R10 internal periodic sync
        L = 4; B = 2; D = 0;
        load_cfg(1, 20);
        t1 = -1;
        for (int i = 0; i < 30 && t1 < 0; i++) begin
            @(negedge clk);
            if (burst_active) begin
                t1 = cyc;
                chk("R10 first frame count 0", 32'(ch_out), 32'(model(0)));
            end
        end
        chk("R10 internal sync seen", 32'(t1 >= 0), 32'd1);
        while (burst_active) @(negedge clk);
        t2 = -1;
        for (int i = 0; i < 30 && t2 < 0; i++) begin
            @(negedge clk);
            if (burst_active) t2 = cyc;
        end
        chk("R10 period spacing", 32'(t2 - t1), 32'd20);
        wr(1, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule